// File: doc/BRIEF.md
# Bounded Triangular Duty Sweeper

This block drives two compare values for a PWM so that its duty cycle rises and falls in a triangle pattern. It takes a one-cycle `tick` pulse, normally the PWM's periodic interrupt, and counts those pulses. On every tenth pulse both compare values move one count in the direction each is currently travelling.

Each channel has its own lower and upper bound and its own direction bit. When a channel reaches a bound, its direction flips and the value moves one count the other way in that same update, so a value never sits on a bound for two updates in a row. A one-cycle write strobe goes out with every update so that a PWM can latch the two new values into its shadow compare registers. The block does not generate the waveform itself.

Top module: `duty_sweeper`

## Requirements
- R1: After reset, `cmp_a` is 1000, `cmp_b` is 625, `cmp_wr` is 0, both directions are up and the tick count is zero. The first update therefore comes on the tenth tick after reset, even if ticks arrived before the reset.
- R2: Only ticks advance the count. On ticks one to nine of each group of ten, and on any cycle with `tick` low, both compare values hold their value and `cmp_wr` stays low.
- R3: In an update, a value that is travelling up and is below its upper bound rises by 1.
- R4: In an update, a value that is travelling up and equals its upper bound turns to travel down and falls by 1 in that same update.
- R5: In an update, a value that is travelling down and equals its lower bound turns to travel up and rises by 1 in that same update.
- R6: In an update, a value that is travelling down and is above its lower bound falls by 1.
- R7: The two channels move independently. Channel A uses bounds 5 to 1000 and channel B uses bounds 5 to 625, and each keeps its own direction.
- R8: `cmp_wr` is high for exactly the one cycle in which the new compare values first appear on the outputs. That is the cycle after the clock edge that samples the tenth tick.
- R9: Each compare value always stays inside its own bounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Update pulse, counted when high at a clock edge |
| cmp_a | output | 16 | Compare value for channel A |
| cmp_b | output | 16 | Compare value for channel B |
| cmp_wr | output | 1 | One-cycle strobe that marks new compare values |

## Verification
The stimulus drives enough ticks for channel A to fall from 1000 to 5 and climb back to 1000, while channel B turns around several times. Every turnaround update is compared against the model. A design that pauses at a bound would repeat the bound value. A design that steps past a bound would leave the range. A design that turns one channel using the other channel's bounds would put B out of step with the model.

Idle cycles are placed between ticks to catch a counter that counts clock cycles instead of ticks. A reset is also applied while the tick count is partway through a group. A design that failed to clear the count would then update before the tenth tick after reset.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;

    typedef struct packed {
        logic wr;
    } strobe_state_t;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int TICKS_PER_STEP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic step
);
    localparam int CW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == LAST);
        if (tick) begin
            if (wrap) st_d.cnt = '0;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step = wrap;

endmodule

// File: rtl/sweep_channel.sv
module sweep_channel
    import sweep_pkg::*;
#(
    parameter int W  = 16,
    parameter int LO = 5,
    parameter int HI = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    typedef struct packed {
        logic [W-1:0] val;
        sweep_dir_e   dir;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            unique case (st_q.dir)
                DIR_UP: begin
                    if (st_q.val < HI_V) begin
                        st_d.val = st_q.val + 1'b1;
                    end else begin
                        st_d.dir = DIR_DOWN;
                        st_d.val = st_q.val - 1'b1;
                    end
                end
                DIR_DOWN: begin
                    if (st_q.val == LO_V) begin
                        st_d.dir = DIR_UP;
                        st_d.val = st_q.val + 1'b1;
                    end else begin
                        st_d.val = st_q.val - 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= HI_V;
            st_q.dir <= DIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;

endmodule

// File: rtl/duty_sweeper.sv
module duty_sweeper
    import sweep_pkg::*;
#(
    parameter int W              = 16,
    parameter int TICKS_PER_STEP = 10,
    parameter int A_MIN          = 5,
    parameter int A_MAX          = 1000,
    parameter int B_MIN          = 5,
    parameter int B_MAX          = 625
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output logic         cmp_wr
);
    localparam int NCH = 2;
    localparam int LO_TAB [NCH] = '{A_MIN, B_MIN};
    localparam int HI_TAB [NCH] = '{A_MAX, B_MAX};

    logic         step;
    logic [W-1:0] vals [NCH];

    tick_divider #(
        .TICKS_PER_STEP(TICKS_PER_STEP)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .step (step)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        sweep_channel #(
            .W (W),
            .LO(LO_TAB[ch]),
            .HI(HI_TAB[ch])
        ) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .step (step),
            .value(vals[ch])
        );
    end

    strobe_state_t sb_d, sb_q;

    always_comb begin
        sb_d    = sb_q;
        sb_d.wr = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign cmp_a  = vals[0];
    assign cmp_b  = vals[1];
    assign cmp_wr = sb_q.wr;

endmodule

// File: rtl/duty_sweeper_chk.sv
module duty_sweeper_chk #(
    parameter int W     = 16,
    parameter int A_MIN = 5,
    parameter int A_MAX = 1000,
    parameter int B_MIN = 5,
    parameter int B_MAX = 625
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] cmp_a,
    input logic [W-1:0] cmp_b,
    input logic         cmp_wr
);
    // R2: a cycle without a tick leaves both values untouched
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(cmp_a) && $stable(cmp_b)));

    // R8: any change of a value carries the strobe
    a_r8_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_a != $past(cmp_a)) || (cmp_b != $past(cmp_b))) |-> cmp_wr);

    // R3/R4/R5/R6: a strobed update moves each value by exactly one
    a_r3_unit_step_a: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |-> ((cmp_a == W'($past(cmp_a) + 1'b1)) || (cmp_a == W'($past(cmp_a) - 1'b1))));

    a_r6_unit_step_b: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |-> ((cmp_b == W'($past(cmp_b) + 1'b1)) || (cmp_b == W'($past(cmp_b) - 1'b1))));

    // R9: values remain within their own bounds
    a_r9_a_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a >= W'(A_MIN)) && (cmp_a <= W'(A_MAX)));

    a_r9_b_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b >= W'(B_MIN)) && (cmp_b <= W'(B_MAX)));

endmodule

bind duty_sweeper duty_sweeper_chk #(
    .W    (W),
    .A_MIN(A_MIN),
    .A_MAX(A_MAX),
    .B_MIN(B_MIN),
    .B_MAX(B_MAX)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .cmp_wr(cmp_wr)
);

// File: tb/duty_sweeper_bench.sv
module duty_sweeper_bench;
    localparam int W     = 16;
    localparam int A_MIN = 5;
    localparam int A_MAX = 1000;
    localparam int B_MIN = 5;
    localparam int B_MAX = 625;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    logic         cmp_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    duty_sweeper u_duty_sweeper (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .cmp_wr(cmp_wr)
    );

    typedef struct {
        int    a;
        int    b;
        bit    wr;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state
    int m_cnt;
    int m_a, m_b;
    bit m_a_down, m_b_down;

    task automatic model_reset();
        m_cnt = 0; m_a = A_MAX; m_b = B_MAX; m_a_down = 0; m_b_down = 0;
    endtask

    task automatic chan_step(inout int v, inout bit down, input int lo, input int hi,
                             output string tag);
        if (!down) begin
            if (v < hi) begin v = v + 1; tag = "R3"; end
            else begin down = 1; v = v - 1; tag = "R4"; end
        end else begin
            if (v == lo) begin down = 0; v = v + 1; tag = "R5"; end
            else begin v = v - 1; tag = "R6"; end
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic drive(input bit t);
        exp_t  e;
        string tb_tag;
        @(negedge clk);
        tick = t;
        e.wr  = 0;
        e.tag = "R2";
        if (t) begin
            m_cnt++;
            if (m_cnt == 10) begin
                m_cnt = 0;
                chan_step(m_a, m_a_down, A_MIN, A_MAX, e.tag);
                chan_step(m_b, m_b_down, B_MIN, B_MAX, tb_tag);
                e.wr = 1;
            end
        end
        e.a = m_a;
        e.b = m_b;
        exp_q.push_back(e);
    endtask

    // monitor: compares design outputs after each edge
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            check(it.tag, int'(cmp_a), it.a);
            check("R7", int'(cmp_b), it.b);
            check("R8", int'(cmp_wr), int'(it.wr));
            check("R9", int'((cmp_a >= A_MIN) && (cmp_a <= A_MAX)), 1);
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1", int'(cmp_a), A_MAX);
        check("R1", int'(cmp_b), B_MAX);
        check("R1", int'(cmp_wr), 0);

        // R2: idle cycles do not count
        for (int i = 0; i < 15; i++) drive(1'b0);

        // long sweep with gaps: A falls to its floor and climbs back
        for (int i = 0; i < 20200; i++) begin
            drive(1'b1);
            if (i % 7 == 3) drive(1'b0);
        end
        drive(1'b0);
        drive(1'b0);
        @(negedge clk);

        // R1: reset mid-group clears the tick count
        for (int i = 0; i < 5; i++) drive(1'b1);
        @(negedge clk);
        tick = 1'b0;
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(cmp_a), A_MAX);
        check("R1", int'(cmp_b), B_MAX);
        for (int i = 0; i < 12; i++) drive(1'b1);
        drive(1'b0);
        drive(1'b0);
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule